// File: doc/BRIEF.md
# Table-Driven Mealy Step Sequencer

This block is an eight-state sequencer. Its next state and its output come from a constant lookup table. Two control inputs and the three present-state bits form the table index. On every clock edge the block loads the table's next-state field into its state register. The output field drives a combinational pulse that depends on both the present inputs and the present state, so the machine is a Mealy machine.

A force input jumps the machine to the top state. With both controls low, the state counts upward and holds at the top. With only the down control high, the state falls by two and cannot go below zero. The pulse fires only on a downward step taken from state 2 or from state 6. A registered copy of the pulse is also provided, one cycle late and free of glitches. An active-low asynchronous reset returns the machine to state 0.

Top module: `seq_step_fsm`

## Requirements
- R1: While rst_ni is low, state_o reads 0 and pulse_q_o reads 0, whatever the inputs and the clock are doing.
- R2: When force_i is 1 at a clock edge, state_o becomes 7 after that edge, whatever down_i and the present state are. pulse_o is 0 for as long as force_i is 1.
- R3: When force_i and down_i are both 0 at a clock edge, state_o advances by one (0 to 1 and onward up to 7), and state 7 stays at 7.
- R4: When force_i is 0 and down_i is 1 at a clock edge, states 0, 1 and 2 go to 0, and every state s of 3 or more goes to s-2.
- R5: pulse_o is 1 exactly when force_i is 0, down_i is 1 and state_o is 2 or 6. It follows those signals in the same cycle, with no register in the path.
- R6: pulse_q_o equals the value pulse_o had just before the most recent clock edge.
- R7: The table index is {force_i, down_i, state_o}, 32 entries in all. Every one of the 32 combinations yields the next state and pulse given by R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| force_i | input | 1 | Jump to the top state |
| down_i | input | 1 | Step down by two when high, count up when low |
| state_o | output | 3 | Present state |
| pulse_o | output | 1 | Combinational Mealy pulse |
| pulse_q_o | output | 1 | pulse_o registered by one cycle |

## Verification
A wrong table entry or a corrupted state register shows up at state_o on the clock edge right after that entry is used. If the bad entry is one of the two pulse positions, pulse_o is wrong in the same cycle. Because the state is visible on the ports and the pulse depends on it, a wrong state cannot stay hidden for more than one cycle. The bench therefore drives every one of the 32 index values from a freshly reached state and compares the results against its model on every clock. It also runs a descent from state 7 with down_i held high, which exercises the floor at zero.

// File: rtl/seq_step_pkg.sv
package seq_step_pkg;
  localparam int unsigned SEQ_STATE_W = 3;
  localparam int unsigned SEQ_STEP_DN = 2;
  localparam int unsigned SEQ_PULSE_A = 2;
  localparam int unsigned SEQ_PULSE_B = 6;
endpackage

// File: rtl/seq_step_lut.sv
module seq_step_lut #(
  parameter int unsigned STATE_W = seq_step_pkg::SEQ_STATE_W,
  parameter int unsigned STEP_DN = seq_step_pkg::SEQ_STEP_DN,
  parameter int unsigned PULSE_A = seq_step_pkg::SEQ_PULSE_A,
  parameter int unsigned PULSE_B = seq_step_pkg::SEQ_PULSE_B,
  localparam int unsigned ADDR_W = STATE_W + 2
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [STATE_W-1:0] nxt_o,
  output logic               pulse_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned TOP   = (1 << STATE_W) - 1;

  // entry = {pulse, next_state}
  function automatic logic [STATE_W:0] entry_f(input int unsigned a);
    int unsigned st, nx;
    logic dn, fr, p;
    st = a % (TOP + 1);
    dn = ((a >> STATE_W) & 1) != 0;
    fr = ((a >> (STATE_W + 1)) & 1) != 0;
    p  = 1'b0;
    if (fr)            nx = TOP;
    else if (!dn)      nx = (st == TOP) ? TOP : st + 1;
    else begin
      nx = (st < STEP_DN) ? 0 : st - STEP_DN;
      p  = (st == PULSE_A) || (st == PULSE_B);
    end
    return {p, nx[STATE_W-1:0]};
  endfunction

  logic [STATE_W:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam logic [STATE_W:0] ENTRY = entry_f(g);
    assign rom[g] = ENTRY;
  end

  assign {pulse_o, nxt_o} = rom[addr_i];
endmodule

// File: rtl/seq_step_reg.sv
module seq_step_reg #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/seq_step_fsm.sv
module seq_step_fsm #(
  parameter int unsigned STATE_W = seq_step_pkg::SEQ_STATE_W,
  parameter int unsigned STEP_DN = seq_step_pkg::SEQ_STEP_DN,
  parameter int unsigned PULSE_A = seq_step_pkg::SEQ_PULSE_A,
  parameter int unsigned PULSE_B = seq_step_pkg::SEQ_PULSE_B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               force_i,
  input  logic               down_i,
  output logic [STATE_W-1:0] state_o,
  output logic               pulse_o,
  output logic               pulse_q_o
);
  localparam logic [STATE_W-1:0] TOP = '1;
  localparam logic [STATE_W-1:0] STP = STATE_W'(STEP_DN);
  localparam logic [STATE_W-1:0] PA  = STATE_W'(PULSE_A);
  localparam logic [STATE_W-1:0] PB  = STATE_W'(PULSE_B);

  logic [STATE_W-1:0] state_d;

  seq_step_lut #(
    .STATE_W(STATE_W), .STEP_DN(STEP_DN), .PULSE_A(PULSE_A), .PULSE_B(PULSE_B)
  ) i_lut (
    .addr_i ({force_i, down_i, state_o}),
    .nxt_o  (state_d),
    .pulse_o(pulse_o)
  );

  seq_step_reg #(.W(STATE_W)) i_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(state_d), .q_o(state_o)
  );

  seq_step_reg #(.W(1)) i_pulse_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pulse_o), .q_o(pulse_q_o)
  );

  a_r2_force_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> state_o == TOP);
  a_r2_force_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> !pulse_o);
  a_r3_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !down_i && state_o != TOP) |=> state_o == $past(state_o) + STATE_W'(1));
  a_r3_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !down_i && state_o == TOP) |=> state_o == TOP);
  a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && down_i && state_o >= STP) |=> state_o == $past(state_o) - STP);
  a_r4_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && down_i && state_o < STP) |=> state_o == '0);
  a_r5_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (!force_i && down_i && (state_o == PA || state_o == PB)));
  a_r5_pulse_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && down_i && (state_o == PA || state_o == PB)) |-> pulse_o);
  a_r6_pulse_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pulse_q_o == $past(pulse_o));
endmodule

// File: tb/test_seq_step_fsm.sv
module test_seq_step_fsm;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic force_i = 1'b0;
  logic down_i = 1'b0;
  logic [2:0] state_o;
  logic pulse_o, pulse_q_o;
  int errors = 0;
  int checks = 0;
  int ref_state = 0;
  int ref_pq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seq_step_fsm i_seq_step_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .force_i(force_i), .down_i(down_i),
    .state_o(state_o), .pulse_o(pulse_o), .pulse_q_o(pulse_q_o)
  );

  function automatic int model_next(int f, int d, int s);
    if (f != 0) return 7;
    if (d == 0) return (s == 7) ? 7 : s + 1;
    return (s < 3) ? 0 : s - 2;
  endfunction

  function automatic int model_pulse(int f, int d, int s);
    return (f == 0 && d != 0 && (s == 2 || s == 6)) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic step(int f, int d, string req);
    force_i = f[0];
    down_i  = d[0];
    #1;
    check({req, " state"}, int'(state_o), ref_state);
    check({req, " pulse R5"}, int'(pulse_o), model_pulse(f, d, ref_state));
    check({req, " pulse_q R6"}, int'(pulse_q_o), ref_pq);
    @(posedge clk);
    ref_pq = model_pulse(f, d, ref_state);
    ref_state = model_next(f, d, ref_state);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    force_i = 1'b0;
    down_i  = 1'b0;
    #1;
    check("R1 state in reset", int'(state_o), 0);
    check("R1 pulse_q in reset", int'(pulse_q_o), 0);
    @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    ref_state = 0;
    ref_pq = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 state after power-up reset", int'(state_o), 0);
    check("R1 pulse_q after power-up reset", int'(pulse_q_o), 0);
    rst_ni = 1'b1;

    // R7: every index {force, down, state}
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset();
        for (int k = 0; k < s; k++) step(0, 0, "R3 climb");
        step(c >> 1, c & 1, "R7 index");
        check("R7 next state", int'(state_o), model_next(c >> 1, c & 1, s));
      end
    end

    // R2/R4: force to top, then descend with down held high
    step(1, 0, "R2 force");
    check("R2 top reached", int'(state_o), 7);
    step(0, 1, "R4 down");
    check("R4 7->5", int'(state_o), 5);
    step(0, 1, "R4 down");
    check("R4 5->3", int'(state_o), 3);
    step(0, 1, "R4 down");
    check("R4 3->1", int'(state_o), 1);
    step(0, 1, "R4 down");
    check("R4 floor 1->0", int'(state_o), 0);
    step(0, 1, "R4 floor hold");
    check("R4 floor 0->0", int'(state_o), 0);

    // R3 saturation and R2 with down high
    for (int k = 0; k < 9; k++) step(0, 0, "R3 count");
    check("R3 saturate at 7", int'(state_o), 7);
    step(0, 1, "R4 down");
    step(1, 1, "R2 force with down");
    check("R2 force overrides down", int'(state_o), 7);

    // R1: asynchronous reset mid-cycle
    step(0, 1, "R4 down");
    step(0, 1, "R5 from 5");
    #1;
    rst_ni = 1'b0;
    #1;
    check("R1 async state clear", int'(state_o), 0);
    check("R1 async pulse_q clear", int'(pulse_q_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    ref_state = 0;
    ref_pq = 0;
    step(0, 0, "R1 after reset");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule